// File: doc/BRIEF.md
# Circulating Delay-Line Word Store

This block models a bank of recirculating serial memory tanks with plain shift registers. Every tank holds a fixed train of words. The train moves one bit per clock without stopping and is fed back into the tank's input. One free-running bit counter and one word counter are shared by all tanks, and together they name the slot now leaving each tank. A word cannot be fetched on demand. The requester raises an access with a short-word address, then waits until the addressed word comes round to the tank output. While that word passes, the store matches the running counters against the decoded address. During that match it shows the stored bits on a serial read stream and takes replacement bits from a serial write stream.

Each word slot is 36 bit-times long and is sent least significant bit first. Positions 0 to 16 hold the low half word. Position 17 is the middle bit that joins the two halves. Positions 18 to 34 hold the high half word. Position 35 is a spare guard bit that no access reaches. The short-word address is arranged from high to low as {tank, word, half}. A full-word access uses positions 0 to 34. A half-word access touches only the half chosen by the lowest address bit.

The write stream offers valid/ready signalling, but the store cannot stall, because the tank never stops moving. `wr_ready` marks the bit-times at which a write bit is consumed. A source that holds `wr_valid` low at such a bit lets the stored bit recirculate unchanged. The read stream has no ready input: `rd_bit` is meaningful only in a cycle where `rd_valid` is high, and it is not held for the reader.

Top module: `dline_store`

## Requirements
- R1: Reset sets `slot_bit` and `slot_word` to 0 and clears every stored bit, so that a full read of any word then returns 0.
- R2: `slot_bit` steps by one each clock from 0 to SLOT_BITS-1 and then returns to 0. `slot_word` steps by one each time `slot_bit` wraps, and after the last word of a tank it returns to 0.
- R3: `tank_sel` is the one-hot decode of the tank field (the top address bits) while `acc_en` is high, and it is all zeros while `acc_en` is low.
- R4: `slot_match` is high exactly while `acc_en` is high and `slot_word` equals the word field (address bits [WORD_W:1]). For one access it therefore lasts the 36 bit-times of the addressed slot and falls when the next word begins.
- R5: A full-word access sets `rd_valid` at positions 0 to 34 of the matched slot. `rd_bit` carries the stored bit at position `slot_bit` of the selected word, and `rd_bit` is 0 whenever `rd_valid` is low.
- R6: A write access (`acc_wr`=1) raises `wr_ready` at exactly the positions where `rd_valid` is high. When `wr_valid` is also high, `wr_bit` replaces the stored bit, and the new value is read back on the next revolution. In the write cycle itself, `rd_bit` still shows the old bit.
- R7: If `wr_valid` is low during a `wr_ready` bit-time, the stored bit at that position is kept.
- R8: A half-word access with `acc_addr[0]`=0 covers positions 0 to 16. With `acc_addr[0]`=1 it covers positions 18 to 34. In both cases position 17 and the other half are never presented or written.
- R9: Stored words recirculate unchanged through any number of revolutions. A write changes no other word and no other tank.
- R10: `rd_valid` is never high without `slot_match`, and `wr_ready` is never high without both `slot_match` and `acc_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access request held while waiting for and during the slot |
| acc_addr | input | ADDR_W | Short-word address {tank, word, half} |
| acc_wr | input | 1 | 1 = write access, 0 = read access |
| acc_half | input | 1 | 1 = half-word access, 0 = full-word access |
| wr_valid | input | 1 | Write bit present |
| wr_bit | input | 1 | Serial write data |
| wr_ready | output | 1 | Store consumes a write bit this cycle |
| rd_valid | output | 1 | `rd_bit` is meaningful this cycle |
| rd_bit | output | 1 | Serial read data, least significant bit first |
| slot_match | output | 1 | Addressed word is at the tank outputs |
| slot_word | output | WORD_W | Running word-slot counter |
| slot_bit | output | BIT_W | Running bit-position counter |
| tank_sel | output | NUM_TANKS | One-hot tank decode |

## Verification
The bench builds the store with four tanks of four words each and keeps the half word at 17 bits. The slot format is therefore the real 36-bit layout, while one revolution takes only 144 clocks. At this size every tank code and every word code can be reached. The word counter wraps many times, and neighbouring words and tanks can be checked after each write. Repeated revolutions, masked write bits and both half-word selections each fit into a few thousand cycles.

// File: rtl/dline_pkg.sv
package dline_pkg;

  // Classification of a bit position inside one word slot.
  typedef enum logic [1:0] {
    FLD_LOW   = 2'd0,
    FLD_MID   = 2'd1,
    FLD_HIGH  = 2'd2,
    FLD_GUARD = 2'd3
  } slot_field_e;

  // Map a slot position to its field, given the half-word width.
  function automatic slot_field_e field_of(input int unsigned pos,
                                           input int unsigned half_w);
    if (pos < half_w)            return FLD_LOW;
    else if (pos == half_w)      return FLD_MID;
    else if (pos <= 2 * half_w)  return FLD_HIGH;
    else                         return FLD_GUARD;
  endfunction

endpackage

// File: rtl/slot_timer.sv
module slot_timer #(
  parameter int SLOT_BITS = 36,
  parameter int WORDS     = 16,
  localparam int BIT_W    = $clog2(SLOT_BITS),
  localparam int WORD_W   = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic [WORD_W-1:0] word_cnt
);

  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(SLOT_BITS - 1);
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(WORDS - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_cnt  <= '0;
      word_cnt <= '0;
    end else if (bit_cnt == LAST_BIT) begin
      bit_cnt  <= '0;
      word_cnt <= (word_cnt == LAST_WORD) ? '0 : word_cnt + 1'b1;
    end else begin
      bit_cnt  <= bit_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import dline_pkg::*;
#(
  parameter int NUM_TANKS = 16,
  parameter int WORDS     = 16,
  parameter int HALF_BITS = 17,
  localparam int SLOT_BITS = 2 * HALF_BITS + 2,
  localparam int BIT_W     = $clog2(SLOT_BITS),
  localparam int WORD_W    = $clog2(WORDS),
  localparam int TANK_W    = $clog2(NUM_TANKS),
  localparam int ADDR_W    = TANK_W + WORD_W + 1
) (
  input  logic                 acc_en,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 acc_half,
  input  logic [BIT_W-1:0]     bit_cnt,
  input  logic [WORD_W-1:0]    word_cnt,
  output logic [NUM_TANKS-1:0] tank_sel,
  output logic                 slot_match,
  output logic                 field_hit
);

  logic [TANK_W-1:0] tank_f;
  logic [WORD_W-1:0] word_f;
  logic              half_f;
  slot_field_e       fld;

  assign half_f = acc_addr[0];
  assign word_f = acc_addr[WORD_W:1];
  assign tank_f = acc_addr[ADDR_W-1:WORD_W+1];

  // Parallel tank decode: one comparator per tank.
  for (genvar t = 0; t < NUM_TANKS; t++) begin : g_sel
    assign tank_sel[t] = acc_en && (tank_f == TANK_W'(t));
  end

  // Coincidence of the requested word with the running word counter.
  assign slot_match = (|tank_sel) && (word_f == word_cnt);

  always_comb begin
    fld = field_of(int'(bit_cnt), HALF_BITS);
    if (!acc_half)   field_hit = (fld != FLD_GUARD);
    else if (half_f) field_hit = (fld == FLD_HIGH);
    else             field_hit = (fld == FLD_LOW);
  end

endmodule

// File: rtl/delay_tank.sv
module delay_tank #(
  parameter int LINE_BITS = 576
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic wr_bit,
  output logic out_bit
);

  logic [LINE_BITS-1:0] line;
  logic                 feed;

  assign out_bit = line[0];
  // Regeneration: the leaving bit goes back in unless it is replaced.
  assign feed    = wr_en ? wr_bit : line[0];

  always_ff @(posedge clk) begin
    if (!rst_n) line <= '0;
    else        line <= {feed, line[LINE_BITS-1:1]};
  end

endmodule

// File: rtl/dline_store.sv
module dline_store #(
  parameter int NUM_TANKS      = 16,
  parameter int WORDS_PER_TANK = 16,
  parameter int HALF_BITS      = 17,
  localparam int SLOT_BITS = 2 * HALF_BITS + 2,
  localparam int LINE_BITS = SLOT_BITS * WORDS_PER_TANK,
  localparam int BIT_W     = $clog2(SLOT_BITS),
  localparam int WORD_W    = $clog2(WORDS_PER_TANK),
  localparam int TANK_W    = $clog2(NUM_TANKS),
  localparam int ADDR_W    = TANK_W + WORD_W + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic                 acc_wr,
  input  logic                 acc_half,
  input  logic                 wr_valid,
  input  logic                 wr_bit,
  output logic                 wr_ready,
  output logic                 rd_valid,
  output logic                 rd_bit,
  output logic                 slot_match,
  output logic [WORD_W-1:0]    slot_word,
  output logic [BIT_W-1:0]     slot_bit,
  output logic [NUM_TANKS-1:0] tank_sel
);

  logic                 field_hit;
  logic [NUM_TANKS-1:0] tank_out;

  slot_timer #(
    .SLOT_BITS (SLOT_BITS),
    .WORDS     (WORDS_PER_TANK)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_cnt  (slot_bit),
    .word_cnt (slot_word)
  );

  addr_decode #(
    .NUM_TANKS (NUM_TANKS),
    .WORDS     (WORDS_PER_TANK),
    .HALF_BITS (HALF_BITS)
  ) u_dec (
    .acc_en     (acc_en),
    .acc_addr   (acc_addr),
    .acc_half   (acc_half),
    .bit_cnt    (slot_bit),
    .word_cnt   (slot_word),
    .tank_sel   (tank_sel),
    .slot_match (slot_match),
    .field_hit  (field_hit)
  );

  assign rd_valid = slot_match && field_hit;
  assign wr_ready = rd_valid && acc_wr;

  for (genvar t = 0; t < NUM_TANKS; t++) begin : g_tank
    delay_tank #(
      .LINE_BITS (LINE_BITS)
    ) u_tank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tank_sel[t] && wr_ready && wr_valid),
      .wr_bit  (wr_bit),
      .out_bit (tank_out[t])
    );
  end

  assign rd_bit = rd_valid && (|(tank_out & tank_sel));

endmodule

// File: rtl/dline_store_chk.sv
module dline_store_chk #(
  parameter int NUM_TANKS      = 16,
  parameter int WORDS_PER_TANK = 16,
  parameter int HALF_BITS      = 17,
  localparam int SLOT_BITS = 2 * HALF_BITS + 2,
  localparam int BIT_W     = $clog2(SLOT_BITS),
  localparam int WORD_W    = $clog2(WORDS_PER_TANK)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 acc_en,
  input logic                 acc_wr,
  input logic                 acc_half,
  input logic                 wr_ready,
  input logic                 rd_valid,
  input logic                 rd_bit,
  input logic                 slot_match,
  input logic [WORD_W-1:0]    slot_word,
  input logic [BIT_W-1:0]     slot_bit,
  input logic [NUM_TANKS-1:0] tank_sel
);

  localparam logic [BIT_W-1:0]  LAST_B = BIT_W'(SLOT_BITS - 1);
  localparam logic [WORD_W-1:0] LAST_W = WORD_W'(WORDS_PER_TANK - 1);
  localparam logic [BIT_W-1:0]  MID_B  = BIT_W'(HALF_BITS);

  // R2
  bit_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_bit == LAST_B |=> slot_bit == '0);
  // R2
  bit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_bit != LAST_B |=> slot_bit == $past(slot_bit) + 1'b1);
  // R2
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_bit != LAST_B |=> $stable(slot_word));
  // R2
  word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_bit == LAST_B |=>
      slot_word == (($past(slot_word) == LAST_W) ? '0 : $past(slot_word) + 1'b1));
  // R3
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tank_sel));
  // R3
  sel_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |-> tank_sel == '0);
  // R4
  match_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_match |-> acc_en);
  // R5
  rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> !rd_bit);
  // R8
  mid_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_half && slot_bit == MID_B) |-> !(rd_valid || wr_ready));
  // R10
  rd_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> slot_match);
  // R10
  wr_in_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (slot_match && acc_wr));

endmodule

bind dline_store dline_store_chk #(
  .NUM_TANKS      (NUM_TANKS),
  .WORDS_PER_TANK (WORDS_PER_TANK),
  .HALF_BITS      (HALF_BITS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .acc_en     (acc_en),
  .acc_wr     (acc_wr),
  .acc_half   (acc_half),
  .wr_ready   (wr_ready),
  .rd_valid   (rd_valid),
  .rd_bit     (rd_bit),
  .slot_match (slot_match),
  .slot_word  (slot_word),
  .slot_bit   (slot_bit),
  .tank_sel   (tank_sel)
);

// File: tb/dline_store_test.sv
module dline_store_test;

  localparam int CLK_P  = 10;
  localparam int NT     = 4;
  localparam int NW     = 4;
  localparam int HB     = 17;
  localparam int SB     = 2 * HB + 2;
  localparam int REV    = SB * NW;
  localparam int NVEC   = 15;
  localparam int WD_CYC = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_en = 1'b0;
  logic [4:0] acc_addr = '0;
  logic       acc_wr = 1'b0;
  logic       acc_half = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_bit = 1'b0;
  logic       wr_ready, rd_valid, rd_bit, slot_match;
  logic [1:0] slot_word;
  logic [5:0] slot_bit;
  logic [3:0] tank_sel;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  always #(CLK_P / 2) clk = ~clk;

  dline_store #(
    .NUM_TANKS      (NT),
    .WORDS_PER_TANK (NW),
    .HALF_BITS      (HB)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_addr   (acc_addr),
    .acc_wr     (acc_wr),
    .acc_half   (acc_half),
    .wr_valid   (wr_valid),
    .wr_bit     (wr_bit),
    .wr_ready   (wr_ready),
    .rd_valid   (rd_valid),
    .rd_bit     (rd_bit),
    .slot_match (slot_match),
    .slot_word  (slot_word),
    .slot_bit   (slot_bit),
    .tank_sel   (tank_sel)
  );

  // Vector layout: {addr[4:0], wr, half, data[34:0], expected_read[34:0]}
  localparam logic [76:0] VECS [NVEC] = '{
    {5'h0C, 1'b1, 1'b0, 35'h1_2346_6789, 35'h0_0000_0000},
    {5'h0C, 1'b0, 1'b0, 35'h0,           35'h1_2346_6789},
    {5'h14, 1'b1, 1'b0, 35'h7_FFFF_FFFF, 35'h0_0000_0000},
    {5'h0C, 1'b0, 1'b0, 35'h0,           35'h1_2346_6789},
    {5'h0C, 1'b1, 1'b1, 35'h7_FFFE_ABCD, 35'h0_0000_6789},
    {5'h0C, 1'b0, 1'b0, 35'h0,           35'h1_2346_ABCD},
    {5'h0D, 1'b1, 1'b1, 35'h5_5557_FFFF, 35'h1_2344_0000},
    {5'h0C, 1'b0, 1'b0, 35'h0,           35'h5_5556_ABCD},
    {5'h0D, 1'b0, 1'b1, 35'h0,           35'h5_5554_0000},
    {5'h0C, 1'b0, 1'b1, 35'h0,           35'h0_0000_ABCD},
    {5'h14, 1'b0, 1'b0, 35'h0,           35'h7_FFFF_FFFF},
    {5'h00, 1'b1, 1'b0, 35'h4_0000_0001, 35'h0_0000_0000},
    {5'h00, 1'b0, 1'b0, 35'h0,           35'h4_0000_0001},
    {5'h02, 1'b0, 1'b0, 35'h0,           35'h0_0000_0000},
    {5'h1E, 1'b0, 1'b0, 35'h0,           35'h0_0000_0000}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Wait for the slot of address a, run the 36 bit-times, return the read word.
  task automatic do_access(input logic [4:0] a, input logic w, input logic h,
                           input logic [34:0] d, input logic [35:0] vmask,
                           output logic [34:0] rdw);
    logic [35:0] dd;
    int bad_match = 0;
    int bad_flow  = 0;
    dd  = {1'b0, d};
    rdw = '0;
    @(negedge clk);
    while (!(slot_word == a[2:1] && slot_bit == 6'd0)) @(negedge clk);
    for (int i = 0; i < SB; i++) begin
      logic exp_v;
      acc_en   = 1'b1;
      acc_addr = a;
      acc_wr   = w;
      acc_half = h;
      wr_bit   = dd[i];
      wr_valid = vmask[i];
      if (!h)        exp_v = (i <= 2 * HB);
      else if (a[0]) exp_v = (i > HB) && (i <= 2 * HB);
      else           exp_v = (i < HB);
      #1;
      if (!slot_match) bad_match++;
      if (rd_valid !== exp_v || wr_ready !== (exp_v && w)) bad_flow++;
      if (rd_valid && i < 35) rdw[i] = rd_bit;
      @(negedge clk);
    end
    #1;
    // R4: strobe lasts exactly one slot; this check also covers the 36 bits before it
    check(bad_match == 0 && !slot_match, "R4", "slot_match window",
          longint'(bad_match), 0);
    // R5 R6 R8 R10: valid/ready positions inside the slot
    check(bad_flow == 0, "R6", "rd_valid/wr_ready positions", longint'(bad_flow), 0);
    acc_en   = 1'b0;
    acc_wr   = 1'b0;
    acc_half = 1'b0;
    wr_valid = 1'b0;
    wr_bit   = 1'b0;
  endtask

  initial begin : watchdog
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    logic [34:0] rw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // R1: counters after reset (one edge out of reset: bit 1)
    check(slot_bit == 6'd1 && slot_word == 2'd0, "R1", "counters after reset",
          longint'({slot_word, slot_bit}), 1);
    check(tank_sel == 4'd0 && !rd_valid && !wr_ready && !slot_match, "R3",
          "idle decode", longint'(tank_sel), 0);

    // R2: counting and word wrap
    while (slot_bit != 6'd0) @(negedge clk);
    check(slot_word == 2'd1, "R2", "word after first wrap", longint'(slot_word), 1);
    repeat (SB - 1) @(negedge clk);
    check(slot_bit == 6'd35 && slot_word == 2'd1, "R2", "last bit of slot",
          longint'(slot_bit), 35);
    repeat (SB * 3 + 1) @(negedge clk);
    check(slot_bit == 6'd0 && slot_word == 2'd1, "R2", "word wraps after last word",
          longint'(slot_word), 1);

    // R3: one-hot tank decode
    acc_en = 1'b1;
    acc_addr = 5'h10;
    #1;
    check(tank_sel == 4'b0100, "R3", "tank 2 decode", longint'(tank_sel), 4);
    acc_addr = 5'h19;
    #1;
    check(tank_sel == 4'b1000, "R3", "tank 3 decode", longint'(tank_sel), 8);
    // R4: no coincidence with a different word (current word is 1, request word 0)
    check(!slot_match && !rd_valid, "R4", "no match off-slot",
          longint'(slot_match), 0);
    acc_en = 1'b0;
    #1;
    check(tank_sel == 4'd0, "R3", "decode off when idle", longint'(tank_sel), 0);

    // R1: reset contents read as zero
    do_access(5'h1A, 1'b0, 1'b0, 35'h0, 36'h0, rw);
    check(rw == 35'h0, "R1", "cleared word", longint'(rw), 0);

    // Table walk: R5 R6 R8 R9
    foreach (VECS[k]) begin
      logic [76:0] v;
      v = VECS[k];
      do_access(v[76:72], v[71], v[70], v[69:35], 36'hF_FFFF_FFFF, rw);
      check(rw == v[34:0], "R5", $sformatf("vector %0d read", k),
            longint'(rw), longint'(v[34:0]));
    end

    // R7: write with wr_valid only on even positions keeps odd bits
    do_access(5'h14, 1'b1, 1'b0, 35'h0, 36'h5_5555_5555, rw);
    do_access(5'h14, 1'b0, 1'b0, 35'h0, 36'h0, rw);
    check(rw == 35'h2_AAAA_AAAA, "R7", "masked write", longint'(rw), 64'h2_AAAA_AAAA);

    // R9: contents survive many revolutions
    repeat (REV * 10) @(negedge clk);
    do_access(5'h0C, 1'b0, 1'b0, 35'h0, 36'h0, rw);
    check(rw == 35'h5_5556_ABCD, "R9", "after 10 revolutions", longint'(rw),
          64'h5_5556_ABCD);
    do_access(5'h00, 1'b0, 1'b0, 35'h0, 36'h0, rw);
    check(rw == 35'h4_0000_0001, "R9", "tank0 word0 kept", longint'(rw),
          64'h4_0000_0001);

    // R8: middle bit survived both half writes (bit 17 of word set by first write)
    do_access(5'h0C, 1'b0, 1'b0, 35'h0, 36'h0, rw);
    check(rw[17] == 1'b1, "R8", "middle bit preserved", longint'(rw[17]), 1);

    // R10: a read access never raises wr_ready even with wr_valid high
    do_access(5'h06, 1'b0, 1'b0, 35'h7_FFFF_FFFF, 36'hF_FFFF_FFFF, rw);
    do_access(5'h06, 1'b0, 1'b0, 35'h0, 36'h0, rw);
    check(rw == 35'h0, "R10", "read access did not write", longint'(rw), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule